// File: doc/BRIEF.md
# Macro-block Raster Address Generator

This block produces the memory addresses needed to read one rectangular macro-block out of a picture slice that is stored row after row in linear memory. It is intended for block-matching engines that compute a sum of absolute differences. Each enabled clock yields one pixel address. The scan walks left to right along a block row. At the end of each row it jumps to the first pixel of the following row.

A controller pulses `start_i` once for each candidate position. The pulse carries the start address, the block width and height, and the slice width (the row pitch in memory). The block latches these values at the pulse. While `gen_en_i` is high it advances by one pixel per clock. When the last pixel has been consumed it raises `done_o` and holds the final address there. It stays in that state until the next start. No multiplier is used: two up-counters, one equality compare per dimension and a single adder do all the work.

Top module: `mb_scan_agen`

## Requirements
- R1: While reset is asserted and after its release, with no start seen, `addr_o` is 0 and `done_o` is 1.
- R2: On the clock after a cycle with `start_i` high, `addr_o` equals the `base_addr_i` sampled in that cycle and `done_o` is 0. `start_i` takes priority over `gen_en_i`.
- R3: An enabled step (`gen_en_i` high, `done_o` low, no start) that is not at a row end increases `addr_o` by exactly 1.
- R4: An enabled step at a row end, except on the last row, increases `addr_o` by (slice width − block width + 1). The address then points at the first pixel of the next block row, so pixel (x, y) is presented at base + y·slice_w + x.
- R5: In a cycle with `gen_en_i` low and no start, `addr_o` and `done_o` do not change.
- R6: For a W×H block, exactly W·H addresses are presented. `done_o` rises on the clock that consumes the last pixel, and `addr_o` keeps the last pixel's address.
- R7: While `done_o` is high, `gen_en_i` has no effect. The address and the done flag hold until the next start.
- R8: A start pulse in the middle of a scan abandons that scan and restarts from the new base address.
- R9: A 1×1 block presents only the base address and finishes after one enabled step.
- R10: Block width, block height, slice width and base address are captured at start. Changes to those inputs during a scan do not alter the sequence.
- R11: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new scan; latches the configuration |
| gen_en_i | input | 1 | Advance one pixel this clock |
| base_addr_i | input | ADDR_W | Address of the block's top-left pixel |
| blk_w_i | input | DIM_W | Block width in pixels, 1 or more |
| blk_h_i | input | DIM_W | Block height in rows, 1 or more |
| slice_w_i | input | SLW_W | Row pitch of the slice in memory, at least the block width |
| addr_o | output | ADDR_W | Current pixel address |
| done_o | output | 1 | All pixels of the block consumed |

## Verification
The bench sweeps every block shape up to 4×4 against three row pitches. It compares every presented address with base + y·pitch + x. A wrong row jump, such as one that misses the +1 or uses the width instead of the pitch, shows up on the first pixel of row two. Stalls are inserted between steps and the configuration inputs are scrambled right after each start. A design that advances without an enable, or one that reads live inputs instead of latched ones, therefore drifts off the expected sequence. Three further cases are covered: 1×1 blocks, where an off-by-one in the end detection would emit extra pixels or finish early; a base address near the top of the address space, to exercise the wrap; and a restart in the middle of a scan.

// File: rtl/mb_scan_pkg.sv
package mb_scan_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_DIM_W  = 6;
  localparam int unsigned DEF_SLW_W  = 12;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_PIX  = 2'd1,
    STEP_ROW  = 2'd2
  } step_kind_e;
endpackage

// File: rtl/mb_axis_cnt.sv
module mb_axis_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         at_last_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign at_last_o = (cnt_q == last_i);
  assign cnt_o     = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)          cnt_d = '0;
    else if (adv_i)     cnt_d = at_last_o ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mb_addr_step.sv
module mb_addr_step
  import mb_scan_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  step_kind_e        kind_i,
  input  logic [ADDR_W-1:0] jump_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d, incr;

  always_comb begin
    unique case (kind_i)
      STEP_PIX: incr = ADDR_W'(1);
      STEP_ROW: incr = jump_i;
      default:  incr = '0;
    endcase
    if (load_i) addr_d = base_i;
    else        addr_d = addr_q + incr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/mb_scan_agen.sv
module mb_scan_agen
  import mb_scan_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DIM_W  = DEF_DIM_W,
  parameter int unsigned SLW_W  = DEF_SLW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              gen_en_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [DIM_W-1:0]  blk_w_i,
  input  logic [DIM_W-1:0]  blk_h_i,
  input  logic [SLW_W-1:0]  slice_w_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  // configuration latched at start
  logic [DIM_W-1:0]  last_x_q, last_x_d;
  logic [DIM_W-1:0]  last_y_q, last_y_d;
  logic [ADDR_W-1:0] row_jump_q, row_jump_d;
  logic              done_q, done_d;

  logic              step;
  logic              x_last, y_last;
  logic [DIM_W-1:0]  col_cnt, row_cnt;
  step_kind_e        kind;

  assign step = gen_en_i && !done_q && !start_i;

  always_comb begin
    last_x_d   = last_x_q;
    last_y_d   = last_y_q;
    row_jump_d = row_jump_q;
    done_d     = done_q;
    if (start_i) begin
      last_x_d   = blk_w_i - DIM_W'(1);
      last_y_d   = blk_h_i - DIM_W'(1);
      row_jump_d = ADDR_W'(slice_w_i) - ADDR_W'(blk_w_i) + ADDR_W'(1);
      done_d     = 1'b0;
    end else if (step && x_last && y_last) begin
      done_d     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      last_x_q   <= '0;
      last_y_q   <= '0;
      row_jump_q <= '0;
      done_q     <= 1'b1;
    end else begin
      last_x_q   <= last_x_d;
      last_y_q   <= last_y_d;
      row_jump_q <= row_jump_d;
      done_q     <= done_d;
    end
  end

  mb_axis_cnt #(.W(DIM_W)) u_col (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (start_i),
    .adv_i     (step),
    .last_i    (last_x_q),
    .cnt_o     (col_cnt),
    .at_last_o (x_last)
  );

  mb_axis_cnt #(.W(DIM_W)) u_row (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (start_i),
    .adv_i     (step && x_last),
    .last_i    (last_y_q),
    .cnt_o     (row_cnt),
    .at_last_o (y_last)
  );

  always_comb begin
    kind = STEP_HOLD;
    if (step && !(x_last && y_last))
      kind = x_last ? STEP_ROW : STEP_PIX;
  end

  mb_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (start_i),
    .base_i (base_addr_i),
    .kind_i (kind),
    .jump_i (row_jump_q),
    .addr_o (addr_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/mb_scan_agen_chk.sv
module mb_scan_agen_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              start_i,
  input logic              gen_en_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic [ADDR_W-1:0] row_jump_q,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);
  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> (addr_o == $past(base_addr_i)) && !done_o);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!start_i && !gen_en_i) |=> $stable(addr_o) && $stable(done_o));

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && !start_i) |=> done_o && $stable(addr_o));

  // R3 and R4: a step moves by one pixel, by the row jump, or finishes in place
  p_step_size_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gen_en_i && !done_o && !start_i) |=>
      (addr_o == $past(addr_o) + ADDR_W'(1)) ||
      (addr_o == $past(addr_o) + $past(row_jump_q)) ||
      (done_o && $stable(addr_o)));

  p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(done_o) |-> $past(gen_en_i) && !$past(start_i));
endmodule

bind mb_scan_agen mb_scan_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .start_i     (start_i),
  .gen_en_i    (gen_en_i),
  .base_addr_i (base_addr_i),
  .row_jump_q  (row_jump_q),
  .addr_o      (addr_o),
  .done_o      (done_o)
);

// File: tb/mb_scan_agen_tb.sv
module mb_scan_agen_tb;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int DIM_W  = 4;
  localparam int SLW_W  = 8;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i, gen_en_i;
  logic [ADDR_W-1:0] base_addr_i;
  logic [DIM_W-1:0]  blk_w_i, blk_h_i;
  logic [SLW_W-1:0]  slice_w_i;
  logic [ADDR_W-1:0] addr_o;
  logic              done_o;

  int checks = 0;
  int failures = 0;
  int stall_k = 0;

  always #(CLK_P/2) clk = ~clk;

  mb_scan_agen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .SLW_W(SLW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gen_en_i(gen_en_i),
    .base_addr_i(base_addr_i), .blk_w_i(blk_w_i), .blk_h_i(blk_h_i),
    .slice_w_i(slice_w_i), .addr_o(addr_o), .done_o(done_o));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic kick(int b, int w, int h, int sw);
    @(negedge clk);
    start_i = 1'b1; gen_en_i = 1'b1;
    base_addr_i = ADDR_W'(b); blk_w_i = DIM_W'(w);
    blk_h_i = DIM_W'(h); slice_w_i = SLW_W'(sw);
    @(negedge clk);
    start_i = 1'b0; gen_en_i = 1'b0;
    chk(addr_o == ADDR_W'(b), "R2 base", int'(addr_o), b & AMASK);
    chk(done_o == 1'b0, "R2 done", int'(done_o), 0);
  endtask

  // steps through a latched scan; stop_at < 0 runs to completion
  task automatic walk(int b, int w, int h, int sw, bit scramble,
                      string dtag, string atag, int stop_at);
    int n = 0;
    int exp = 0;
    if (scramble) begin   // R10: inputs change after start
      blk_w_i = ~blk_w_i; blk_h_i = ~blk_h_i;
      slice_w_i = slice_w_i + 8'd5; base_addr_i = ~base_addr_i;
    end
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        if (stop_at >= 0 && n == stop_at) return;
        exp = (b + y*sw + x) & AMASK;
        if (atag != "")
          chk(int'(addr_o) == exp, atag, int'(addr_o), exp);
        else if (x == 0 && y > 0)
          chk(int'(addr_o) == exp, scramble ? "R4 R10 row jump" : "R4 row jump", int'(addr_o), exp);
        else
          chk(int'(addr_o) == exp, scramble ? "R3 R10 pixel" : "R3 pixel", int'(addr_o), exp);
        chk(done_o == 1'b0, "R6 early done", int'(done_o), 0);
        if (stall_k % 3 == 2) begin
          gen_en_i = 1'b0;
          @(negedge clk);
          chk(int'(addr_o) == exp && !done_o, "R5 stall", int'(addr_o), exp);
        end
        stall_k++;
        gen_en_i = 1'b1;
        @(negedge clk);
        gen_en_i = 1'b0;
        n++;
      end
    end
    exp = (b + (h-1)*sw + (w-1)) & AMASK;
    chk(done_o == 1'b1, dtag, int'(done_o), 1);
    chk(int'(addr_o) == exp, dtag, int'(addr_o), exp);
    gen_en_i = 1'b1;
    repeat (3) @(negedge clk);
    gen_en_i = 1'b0;
    chk(int'(addr_o) == exp && done_o, "R7 hold", int'(addr_o), exp);
  endtask

  initial begin
    #(CLK_P*190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; gen_en_i = 1'b0;
    base_addr_i = '0; blk_w_i = '0; blk_h_i = '0; slice_w_i = '0;
    #(CLK_P*3 + 2);
    chk(addr_o == '0 && done_o, "R1 in reset", int'(addr_o), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(addr_o == '0, "R1 addr", int'(addr_o), 0);
    chk(done_o == 1'b1, "R1 done", int'(done_o), 1);

    for (int w = 1; w <= 4; w++)
      for (int h = 1; h <= 4; h++)
        for (int s = 0; s < 3; s++) begin
          int sw = (s == 0) ? w : (s == 1) ? w + 3 : 11;
          int b  = 37*(w + 2*h) + 5*s;
          kick(b, w, h, sw);
          walk(b, w, h, sw, bit'(s == 1), "R6 finish", "", -1);
        end

    kick(300, 1, 1, 9);
    walk(300, 1, 1, 9, 1'b0, "R9 single pixel", "", -1);

    kick(4094, 4, 3, 8);
    walk(4094, 4, 3, 8, 1'b0, "R6 finish", "R11 wrap", -1);

    kick(100, 4, 4, 10);
    walk(100, 4, 4, 10, 1'b0, "R6 finish", "", 6);
    kick(2000, 3, 2, 7);
    walk(2000, 3, 2, 7, 1'b0, "R8 restart done", "R8 restart", -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule